// File: doc/BRIEF.md
# Mailbox Memory Loader with Running CRC

This block is the device-side end of a register mailbox. A host that can only reach 16-bit registers uses it to load 32-bit words into internal memory. The host sets a starting byte address once. It then writes each word as an upper and a lower half and commits the word through the control register. Each commit produces one write on the memory port, moves the address on by one word, and folds the word into a 16-bit CRC.

Once a whole section is loaded, the host reads the CRC register once and compares it with its own CRC of the section. The CRC engine works one byte per clock. While it runs, the block reports busy and drops every register write it receives.

Top module: `mbox_loader`

## Requirements
- R1: After reset, the CRC register reads 0, both address halves read 0, `mem_we` is low and `busy` is low.
- R2: Register indices are assigned as follows: 1 is the address upper half, 2 the address lower half, 3 the data upper half and 4 the data lower half. Each of these reads back on `rd_data` at the same index. Index 5 is the CRC register, which is read-only, and a write to it leaves the CRC unchanged.
- R3: A write to the control register (index 0) with bit 1 (execute) and bit 2 (write) both set, while the block is not busy, commits the word. In the next cycle `mem_we` is high for exactly one cycle, `mem_addr` equals the current address and `mem_wdata` equals {data upper half, data lower half}.
- R4: Each commit advances the stored address by 4, wrapping modulo 2^32. The new value is visible through the address registers.
- R5: Each commit updates the CRC with the word's four bytes, most significant byte first. The CRC uses polynomial 0x1021, no reflection and no final XOR.
- R6: Control bit 0 clears the CRC to 0. When bit 0 is set in the same write as a commit, the committed word's CRC starts from 0.
- R7: After a commit, `busy` is high for exactly 4 cycles. Bit 0 of a read at index 0 mirrors `busy`.
- R8: Register writes that arrive while `busy` is high are dropped. This covers writes to the address, the data and the control register.
- R9: A control write with execute set but write clear, or with write set but execute clear, produces no memory write and leaves the address, the CRC and `busy` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for the write |
| reg_wdata | input | 16 | Register write value |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | 16 | Read value for `rd_idx` (combinational) |
| mem_we | output | 1 | Memory write pulse |
| mem_addr | output | 32 | Byte address of the memory write |
| mem_wdata | output | 32 | Data of the memory write |
| busy | output | 1 | CRC update in progress |

## Verification
The bench builds the block with its defaults: 16-bit halves, 32-bit words and polynomial 0x1021. With these values a four-cycle busy window follows each commit, and a starting address of 0xFFFFFFFC is enough to reach the address wrap.

An eight-word section exercises the address step and the CRC together. Separate tests place writes inside the busy window and combine the CRC clear with a commit.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_CTRL    = 3'd0,
        IDX_ADDR_HI = 3'd1,
        IDX_ADDR_LO = 3'd2,
        IDX_DATA_HI = 3'd3,
        IDX_DATA_LO = 3'd4,
        IDX_CRC     = 3'd5
    } reg_idx_e;

    localparam int CTRL_CRC_CLR = 0;
    localparam int CTRL_EXEC    = 1;
    localparam int CTRL_WRITE   = 2;
    localparam int STAT_BUSY    = 0;
endpackage

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [IDX_W-1:0]      reg_idx,
    input  logic [HALF_W-1:0]     reg_wdata,
    input  logic                  busy,
    output logic                  commit,
    output logic                  crc_clr,
    output logic [2*HALF_W-1:0]   addr,
    output logic [2*HALF_W-1:0]   data,
    output logic                  mem_we,
    output logic [2*HALF_W-1:0]   mem_addr,
    output logic [2*HALF_W-1:0]   mem_wdata
);
    localparam int WORD_W = 2 * HALF_W;
    localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              mem_we;
        logic [WORD_W-1:0] mem_addr;
        logic [WORD_W-1:0] mem_wdata;
    } regs_t;

    regs_t q, d;
    logic  accept;

    always_comb begin
        d       = q;
        d.mem_we = 1'b0;
        commit  = 1'b0;
        crc_clr = 1'b0;
        accept  = reg_wr && !busy;
        if (accept) begin
            case (reg_idx)
                IDX_CTRL: begin
                    crc_clr = reg_wdata[CTRL_CRC_CLR];
                    if (reg_wdata[CTRL_EXEC] && reg_wdata[CTRL_WRITE]) begin
                        commit      = 1'b1;
                        d.mem_we    = 1'b1;
                        d.mem_addr  = q.addr;
                        d.mem_wdata = q.data;
                        d.addr      = q.addr + STEP;
                    end
                end
                IDX_ADDR_HI: d.addr[WORD_W-1:HALF_W] = reg_wdata;
                IDX_ADDR_LO: d.addr[HALF_W-1:0]      = reg_wdata;
                IDX_DATA_HI: d.data[WORD_W-1:HALF_W] = reg_wdata;
                IDX_DATA_LO: d.data[HALF_W-1:0]      = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr      = q.addr;
    assign data      = q.data;
    assign mem_we    = q.mem_we;
    assign mem_addr  = q.mem_addr;
    assign mem_wdata = q.mem_wdata;
endmodule

// File: rtl/mbox_crc16.sv
module mbox_crc16 #(
    parameter int              WORD_W = 32,
    parameter int              CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              clr,
    input  logic [WORD_W-1:0] word,
    output logic [CRC_W-1:0]  crc,
    output logic              busy
);
    localparam int NBYTES = WORD_W / 8;
    localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

    typedef struct packed {
        logic [CRC_W-1:0]  crc;
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
    } crc_t;

    crc_t q, d;

    function automatic logic [CRC_W-1:0] byte_step(input logic [CRC_W-1:0] c_in,
                                                   input logic [7:0] b);
        logic [CRC_W-1:0] c;
        c = c_in ^ (CRC_W'(b) << (CRC_W - 8));
        for (int i = 0; i < 8; i++) begin
            if (c[CRC_W-1]) c = (c << 1) ^ POLY;
            else            c = c << 1;
        end
        return c;
    endfunction

    always_comb begin
        d = q;
        if (start) begin
            d.crc   = clr ? '0 : q.crc;
            d.shift = word;
            d.cnt   = '0;
            d.busy  = 1'b1;
        end else if (clr) begin
            d.crc = '0;
        end else if (q.busy) begin
            d.crc   = byte_step(q.crc, q.shift[WORD_W-1 -: 8]);
            d.shift = q.shift << 8;
            d.cnt   = q.cnt + 1'b1;
            if (q.cnt == LAST) d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign crc  = q.crc;
    assign busy = q.busy;
endmodule

// File: rtl/mbox_loader.sv
module mbox_loader
    import mbox_pkg::*;
#(
    parameter int                HALF_W   = 16,
    parameter logic [HALF_W-1:0] CRC_POLY = 16'h1021
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [IDX_W-1:0]      reg_idx,
    input  logic [HALF_W-1:0]     reg_wdata,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [HALF_W-1:0]     rd_data,
    output logic                  mem_we,
    output logic [2*HALF_W-1:0]   mem_addr,
    output logic [2*HALF_W-1:0]   mem_wdata,
    output logic                  busy
);
    localparam int WORD_W = 2 * HALF_W;

    logic              commit;
    logic              crc_clr;
    logic [WORD_W-1:0] cur_addr;
    logic [WORD_W-1:0] cur_data;
    logic [HALF_W-1:0] crc_val;

    mbox_regs #(.HALF_W(HALF_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .commit    (commit),
        .crc_clr   (crc_clr),
        .addr      (cur_addr),
        .data      (cur_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    mbox_crc16 #(.WORD_W(WORD_W), .CRC_W(HALF_W), .POLY(CRC_POLY)) crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit),
        .clr   (crc_clr),
        .word  (cur_data),
        .crc   (crc_val),
        .busy  (busy)
    );

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            IDX_CTRL:    rd_data[STAT_BUSY] = busy;
            IDX_ADDR_HI: rd_data = cur_addr[WORD_W-1:HALF_W];
            IDX_ADDR_LO: rd_data = cur_addr[HALF_W-1:0];
            IDX_DATA_HI: rd_data = cur_data[WORD_W-1:HALF_W];
            IDX_DATA_LO: rd_data = cur_data[HALF_W-1:0];
            IDX_CRC:     rd_data = crc_val;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mbox_loader_chk.sv
module mbox_loader_chk #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [2:0]          reg_idx,
    input logic [HALF_W-1:0]   reg_wdata,
    input logic                mem_we,
    input logic [2*HALF_W-1:0] mem_addr,
    input logic [2*HALF_W-1:0] cur_addr,
    input logic                busy
);
    logic [3:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 4'd1;
        else           busy_cnt <= '0;
    end

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cur_addr == mem_addr + (2*HALF_W)'(4));

    a_r7_busy_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r7_busy_max: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt < 4'd4);

    a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_cnt == 4'd4);

    a_r8_no_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !mem_we);

    a_r9_write_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(reg_wr && reg_idx == 3'd0 && reg_wdata[1] && reg_wdata[2]));
endmodule

bind mbox_loader mbox_loader_chk #(.HALF_W(HALF_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .cur_addr  (cur_addr),
    .busy      (busy)
);

// File: tb/mbox_loader_tb_top.sv
module mbox_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [31:0] VEC_WORDS [NVEC] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h3132_3334, 32'hDEAD_BEEF,
        32'h8000_0001, 32'h1234_5678, 32'hA5A5_5A5A, 32'h0F0F_F0F0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [15:0] reg_wdata = '0;
    logic [2:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        busy;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_loader dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .rd_idx(rd_idx), .rd_data(rd_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
    );

    function automatic logic [15:0] crc_word(input logic [15:0] c_in, input logic [31:0] w);
        logic [15:0] c;
        c = c_in;
        for (int b = 3; b >= 0; b--) begin
            c = c ^ {w[b*8 +: 8], 8'h00};
            for (int i = 0; i < 8; i++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [15:0] val);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [15:0] val);
        rd_idx = idx;
        #1;
        val = rd_data;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v, hi, lo;
        logic [15:0] exp_crc;
        logic [31:0] a;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 mem_we", 32'(mem_we), 0);
        chk("R1 busy", 32'(busy), 0);
        rd(3'd5, v); chk("R1 crc", 32'(v), 0);
        rd(3'd1, hi); rd(3'd2, lo); chk("R1 addr", {hi, lo}, 0);

        // R2 register map
        wr(3'd1, BASE[31:16]); wr(3'd2, BASE[15:0]);
        rd(3'd1, hi); rd(3'd2, lo); chk("R2 addr readback", {hi, lo}, BASE);
        wr(3'd3, 16'hAAAA); wr(3'd4, 16'h5555);
        rd(3'd3, hi); rd(3'd4, lo); chk("R2 data readback", {hi, lo}, 32'hAAAA5555);
        wr(3'd5, 16'hFFFF);
        rd(3'd5, v); chk("R2 crc read-only", 32'(v), 0);

        // R3 R4 R5 vector walk
        wr(3'd0, 16'h0001);
        exp_crc = 16'h0000;
        for (int i = 0; i < NVEC; i++) begin
            wr(3'd3, VEC_WORDS[i][31:16]);
            wr(3'd4, VEC_WORDS[i][15:0]);
            wr(3'd0, 16'h0006);
            chk("R3 mem_we", 32'(mem_we), 1);
            chk("R4 mem_addr", mem_addr, BASE + 32'(4 * i));
            chk("R3 mem_wdata", mem_wdata, VEC_WORDS[i]);
            @(negedge clk);
            chk("R3 mem_we pulse", 32'(mem_we), 0);
            repeat (3) @(negedge clk);
            exp_crc = crc_word(exp_crc, VEC_WORDS[i]);
        end
        rd(3'd5, v); chk("R5 section crc", 32'(v), 32'(exp_crc));
        rd(3'd1, hi); rd(3'd2, lo); chk("R4 addr after section", {hi, lo}, BASE + 32'(4 * NVEC));

        // R7 busy length and status bit
        wr(3'd3, 16'hCAFE); wr(3'd4, 16'hF00D);
        wr(3'd0, 16'h0006);
        exp_crc = crc_word(exp_crc, 32'hCAFEF00D);
        rd(3'd0, v); chk("R7 status busy bit", 32'(v[0]), 1);
        n = 0;
        while (busy && n < 20) begin n++; @(negedge clk); end
        chk("R7 busy cycles", 32'(n), 4);
        rd(3'd0, v); chk("R7 status idle", 32'(v), 0);

        // R8 writes dropped while busy
        rd(3'd1, hi); rd(3'd2, lo); a = {hi, lo};
        wr(3'd3, 16'h0102); wr(3'd4, 16'h0304);
        wr(3'd0, 16'h0006);
        exp_crc = crc_word(exp_crc, 32'h01020304);
        wr(3'd2, 16'hBEEF);
        wr(3'd0, 16'h0007);
        wr(3'd3, 16'h1111);
        chk("R8 no commit while busy", 32'(mem_we), 0);
        @(negedge clk);
        rd(3'd1, hi); rd(3'd2, lo); chk("R8 addr kept", {hi, lo}, a + 32'd4);
        rd(3'd3, v); chk("R8 data kept", 32'(v), 32'h0102);
        rd(3'd5, v); chk("R8 crc not cleared", 32'(v), 32'(exp_crc));

        // R9 execute or write alone
        rd(3'd1, hi); rd(3'd2, lo); a = {hi, lo};
        @(negedge clk);
        wr(3'd0, 16'h0002);
        chk("R9 exec only no write", 32'(mem_we), 0);
        chk("R9 exec only busy", 32'(busy), 0);
        wr(3'd0, 16'h0004);
        chk("R9 write only no write", 32'(mem_we), 0);
        rd(3'd1, hi); rd(3'd2, lo); chk("R9 addr unchanged", {hi, lo}, a);
        rd(3'd5, v); chk("R9 crc unchanged", 32'(v), 32'(exp_crc));

        // R6 clear combined with commit, then clear alone
        @(negedge clk);
        wr(3'd3, 16'h5A5A); wr(3'd4, 16'hC3C3);
        wr(3'd0, 16'h0007);
        chk("R6 commit with clear", 32'(mem_we), 1);
        wait_idle();
        rd(3'd5, v); chk("R6 crc from zero", 32'(v), 32'(crc_word(16'h0000, 32'h5A5AC3C3)));
        @(negedge clk);
        wr(3'd0, 16'h0001);
        rd(3'd5, v); chk("R6 clear", 32'(v), 0);

        // R4 address wrap
        @(negedge clk);
        wr(3'd1, 16'hFFFF); wr(3'd2, 16'hFFFC);
        wr(3'd0, 16'h0006);
        chk("R4 wrap mem_addr", mem_addr, 32'hFFFF_FFFC);
        wait_idle();
        rd(3'd1, hi); rd(3'd2, lo); chk("R4 wrapped addr", {hi, lo}, 32'h0);

        finish_run();
    end
endmodule